// File: doc/BRIEF.md
# Half-Bridge Command Interlock

This block sits between a switching controller and the gate drivers of one half-bridge leg. It takes two active-high commands, one asking for the upper switch and one for the lower switch, and turns them into two registered gate commands. The inputs arrive already filtered and synchronised to the block clock. The outputs are never high in the same cycle.

When both commands are high, the block does not force both gates low. It keeps the last granted state. If both commands rise in the same sampled cycle, the upper switch wins. The upper gate is edge-qualified: after its side enable returns, it stays low until the upper command shows a fresh rising edge. The lower gate follows the level of its command whenever its side enable is high.

A global enable from the protection logic cuts both gates at the next edge. A dead-time stage holds a rising gate back until the opposite gate has been low for a parameterised number of cycles.

Top module: `hb_steer`

## Requirements
- R1: `gate_hi` and `gate_lo` are never both 1 in the same cycle.
- R2: While `rst_n` is 0 at a clock edge, both gates are 0 after that edge. The remembered grant, the arming state and the input history are cleared. The dead-time counters start saturated.
- R3: When exactly one command is high and the opposite gate has been low long enough (R11), the matching gate is 1 and the other gate is 0 after the next edge.
- R4: When both commands are 0 at an edge, both gates are 0 after that edge.
- R5: When both commands are high and they did not both rise at this edge, the granted state stays the one held before.
- R6: When both commands go from 0 to 1 at the same edge, the upper gate is granted and the lower gate stays 0.
- R7: When a both-high period ends with one command falling, the gates move to the state that the remaining command selects.
- R8: While `hs_en` is 0, `gate_hi` is 0 after each edge. After `hs_en` returns, `gate_hi` stays 0 until `cmd_hi` is seen rising (0 in the previous sampled cycle, 1 now).
- R9: While `ls_en` is 0, `gate_lo` is 0 after each edge. Once `ls_en` is 1 again, `gate_lo` follows `cmd_lo`.
- R10: When `prot_en` is 0 at an edge, both gates are 0 after that edge. The remembered grant is cleared, so a both-high command that follows keeps both gates at 0.
- R11: Suppose a gate falls at edge k and the opposite gate is requested. The opposite gate rises at edge k+DEAD_CYC+1 at the earliest, which gives DEAD_CYC+1 cycles with both gates low. A gate only rises in a cycle after one in which the opposite gate was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_hi | input | 1 | Upper-switch command, filtered and synchronised |
| cmd_lo | input | 1 | Lower-switch command, filtered and synchronised |
| prot_en | input | 1 | Global enable from protection logic; 0 cuts both gates |
| hs_en | input | 1 | Upper-side enable; 0 forces the upper gate low and disarms it |
| ls_en | input | 1 | Lower-side enable; 0 forces the lower gate low |
| gate_hi | output | 1 | Registered upper gate command |
| gate_lo | output | 1 | Registered lower gate command |

## Verification
The embedded properties check on every cycle that the gates are mutually exclusive, that a disabled side or a dropped global enable leaves its gates low after the next edge, and that an idle command pair gives idle gates. They also check that no gate rises straight after a cycle in which the opposite gate was high. The exact length of the dead-time gap, the hold of the granted state under a both-high command, upper-side priority on a simultaneous rise, and the wait for a fresh upper edge after re-enable all depend on history. Only the bench's sequences can show these, checked against a cycle model through every pair of consecutive input vectors.

// File: rtl/hb_steer_pkg.sv
// Package: shared types for the half-bridge command interlock.
// Assumes single-bit gate commands per leg side.
package hb_steer_pkg;

    // Pair of upper/lower signals for one half-bridge leg.
    typedef struct packed {
        logic hi;
        logic lo;
    } leg_pair_t;

    localparam leg_pair_t LEG_IDLE = '{hi: 1'b0, lo: 1'b0};

    // Counter width that can hold values 0..n, never narrower than one bit.
    function automatic int cnt_width(input int n);
        return (n > 0) ? $clog2(n + 1) : 1;
    endfunction

endpackage

// File: rtl/ilk_hist.sv
// Module: ilk_hist
// Keeps the command pair seen at the previous edge so that rising edges can be found.
// Assumes the commands are already synchronous to clk.
module ilk_hist
    import hb_steer_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  leg_pair_t cmd,
    output leg_pair_t prev
);

    // Capture the current command pair for use at the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= LEG_IDLE;
        end else begin
            prev <= cmd;
        end
    end

endmodule

// File: rtl/ilk_hs_arm.sv
// Module: ilk_hs_arm
// Upper-side edge qualification. The upper side is armed by a rising command
// edge while its enable is high, and it is disarmed whenever the enable is low.
// Assumes prev_hi is the command value from the previous edge.
module ilk_hs_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_en,
    input  logic cmd_hi,
    input  logic prev_hi,
    output logic armed_now
);

    logic armed_q;
    logic hi_rise;

    // A fresh rising edge on the upper command.
    assign hi_rise   = cmd_hi & ~prev_hi;
    // Armed for this cycle if already armed or freshly edged, and enabled.
    assign armed_now = hs_en & (armed_q | hi_rise);

    // Remember arming across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else begin
            armed_q <= armed_now;
        end
    end

endmodule

// File: rtl/ilk_decode.sv
// Module: ilk_decode
// Interlock decode: from the command pair, its history and the enables, it
// computes the granted leg state. A both-high command holds the last grant,
// and a simultaneous rise grants the upper side. Stores the grant for the hold.
// Assumes the grant is never both-high (enforced by construction of the cases).
module ilk_decode
    import hb_steer_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  leg_pair_t cmd,
    input  leg_pair_t prev,
    input  logic      prot_en,
    input  logic      armed_now,
    input  logic      ls_en,
    output leg_pair_t grant
);

    leg_pair_t grant_q;
    leg_pair_t raw;
    logic      both_now;
    logic      both_rise;

    assign both_now  = cmd.hi & cmd.lo;
    assign both_rise = both_now & ~prev.hi & ~prev.lo;

    // Choose the raw grant from the command pattern.
    always_comb begin
        if (!prot_en) begin
            raw = LEG_IDLE;
        end else if (both_rise) begin
            raw = '{hi: 1'b1, lo: 1'b0};
        end else if (both_now) begin
            raw = grant_q;
        end else begin
            raw = cmd;
        end
    end

    // Apply the side enables and the upper-side arming.
    always_comb begin
        grant.hi = raw.hi & armed_now;
        grant.lo = raw.lo & ls_en;
    end

    // Remember the grant for the both-high hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= LEG_IDLE;
        end else begin
            grant_q <= grant;
        end
    end

    AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_q.hi && grant_q.lo)); // R1

    AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && both_now && !both_rise && armed_now && ls_en) |=> (grant_q == $past(grant_q))); // R5

endmodule

// File: rtl/ilk_leg_timer.sv
// Module: ilk_leg_timer
// Output register and dead-time counter for one side. The gate rises only when
// the opposite gate is low and reports itself clear. The gate reports clear
// after it has been low for DEAD_CYC counted edges.
// Assumes want is never asserted on both sides at once.
module ilk_leg_timer
    import hb_steer_pkg::*;
#(
    parameter int DEAD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic opp_gate,
    input  logic opp_clear,
    output logic gate,
    output logic clear
);

    localparam int                CW      = cnt_width(DEAD_CYC);
    localparam logic [CW-1:0]     CNT_SAT = CW'(DEAD_CYC);

    logic [CW-1:0] off_cnt;

    // Own side counts as clear once it has been low for the full dead time.
    assign clear = ~gate & (off_cnt == CNT_SAT);

    // Gate register: raise only against a low, clear opposite side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate <= 1'b0;
        end else begin
            gate <= want & ~opp_gate & opp_clear;
        end
    end

    // Off-time counter: restart while high, count up to saturation while low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_cnt <= CNT_SAT;
        end else if (gate) begin
            off_cnt <= '0;
        end else if (off_cnt != CNT_SAT) begin
            off_cnt <= off_cnt + 1'b1;
        end
    end

    AST_RISE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> $past(!opp_gate)); // R11

    AST_FALL_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !want |=> !gate); // R4

endmodule

// File: rtl/hb_steer.sv
// Module: hb_steer (top)
// Half-bridge command interlock. It turns filtered upper and lower commands into
// registered, mutually exclusive gate commands, with both-high hold, upper
// priority on a simultaneous rise, upper edge arming, side and global enables,
// and a dead-time gap of DEAD_CYC+1 cycles between opposite gates.
// Assumes all inputs are synchronous to clk.
module hb_steer
    import hb_steer_pkg::*;
#(
    parameter int DEAD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_hi,
    input  logic cmd_lo,
    input  logic prot_en,
    input  logic hs_en,
    input  logic ls_en,
    output logic gate_hi,
    output logic gate_lo
);

    localparam int SIDES = 2;

    leg_pair_t   cmd;
    leg_pair_t   prev;
    leg_pair_t   grant;
    logic        armed_now;
    logic [SIDES-1:0] want_v;
    logic [SIDES-1:0] gate_v;
    logic [SIDES-1:0] clear_v;

    assign cmd = '{hi: cmd_hi, lo: cmd_lo};

    ilk_hist u_hist (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .prev  (prev)
    );

    ilk_hs_arm u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_en     (hs_en),
        .cmd_hi    (cmd_hi),
        .prev_hi   (prev.hi),
        .armed_now (armed_now)
    );

    ilk_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .prev      (prev),
        .prot_en   (prot_en),
        .armed_now (armed_now),
        .ls_en     (ls_en),
        .grant     (grant)
    );

    // Index 1 is the upper side, index 0 the lower side.
    assign want_v = {grant.hi, grant.lo};

    // One timer per side, each watching the other.
    for (genvar s = 0; s < SIDES; s++) begin : g_side
        ilk_leg_timer #(.DEAD_CYC(DEAD_CYC)) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .want      (want_v[s]),
            .opp_gate  (gate_v[SIDES-1-s]),
            .opp_clear (clear_v[SIDES-1-s]),
            .gate      (gate_v[s]),
            .clear     (clear_v[s])
        );
    end

    assign gate_hi = gate_v[1];
    assign gate_lo = gate_v[0];

    AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo)); // R1

    AST_PROT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en |=> (!gate_hi && !gate_lo)); // R10

    AST_IDLE_CMDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_hi && !cmd_lo) |=> (!gate_hi && !gate_lo)); // R4

    AST_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_en |=> !gate_hi); // R8

    AST_LS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ls_en |=> !gate_lo); // R9

endmodule

// File: tb/tb_hb_steer.sv
// Bench for hb_steer: a directed sequence with hand-computed values, then a
// sweep over every ordered pair of input vectors, checked against a cycle model.
module tb_hb_steer;

    localparam int D = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_hi = 1'b0, cmd_lo = 1'b0, prot_en = 1'b1, hs_en = 1'b1, ls_en = 1'b1;
    logic gate_hi, gate_lo;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Model state.
    int m_ph = 0, m_pl = 0, m_arm = 0, m_th = 0, m_tl = 0;
    int m_gh = 0, m_gl = 0, m_hoff = D, m_loff = D;

    hb_steer #(.DEAD_CYC(D)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .prot_en(prot_en), .hs_en(hs_en), .ls_en(ls_en),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    always #10 clk = ~clk;

    // Cycle model of the requirements, advanced at each edge.
    always @(posedge clk) begin
        int h, l, pe, he, le, rise, arm, rh, rl, nh, nl, gh, gl;
        h = int'(cmd_hi); l = int'(cmd_lo); pe = int'(prot_en); he = int'(hs_en); le = int'(ls_en);
        if (!rst_n) begin
            m_ph = 0; m_pl = 0; m_arm = 0; m_th = 0; m_tl = 0;
            m_gh = 0; m_gl = 0; m_hoff = D; m_loff = D;
        end else begin
            rise = (h == 1 && m_ph == 0) ? 1 : 0;
            arm  = he * ((m_arm + rise) > 0 ? 1 : 0);
            if (pe == 0) begin rh = 0; rl = 0; end
            else if (h + l == 2 && m_ph + m_pl == 0) begin rh = 1; rl = 0; end
            else if (h + l == 2) begin rh = m_th; rl = m_tl; end
            else begin rh = h; rl = l; end
            nh = rh * arm;
            nl = rl * le;
            gh = (nh == 1 && m_gl == 0 && m_loff >= D) ? 1 : 0;
            gl = (nl == 1 && m_gh == 0 && m_hoff >= D) ? 1 : 0;
            m_hoff = (m_gh == 1) ? 0 : ((m_hoff < D) ? m_hoff + 1 : D);
            m_loff = (m_gl == 1) ? 0 : ((m_loff < D) ? m_loff + 1 : D);
            m_gh = gh; m_gl = gl; m_th = nh; m_tl = nl;
            m_ph = h; m_pl = l; m_arm = arm;
        end
    end

    task automatic expect_gates(input int eh, input int el, input string req);
        n_cmp++;
        if (int'(gate_hi) != eh || int'(gate_lo) != el) begin
            n_bad++;
            $display("FAIL %s: gates hi/lo = %0d%0d, expected %0d%0d", req, gate_hi, gate_lo, eh, el);
        end
    endtask

    task automatic check_model(input string req);
        expect_gates(m_gh, m_gl, req);
        n_cmp++;
        if (gate_hi && gate_lo) begin
            n_bad++;
            $display("FAIL R1: gates hi/lo = 11, expected not both high");
        end
    endtask

    // Apply inputs at a falling edge and return at the next falling edge.
    task automatic cyc(input logic h, input logic l, input logic pe, input logic he, input logic le);
        cmd_hi = h; cmd_lo = l; prot_en = pe; hs_en = he; ls_en = le;
        @(negedge clk);
    endtask

    function automatic string tag_of(input logic [4:0] v);
        if (!v[2]) return "R10";
        if (v[4] && v[3]) return "R5";
        if (!v[1]) return "R8";
        if (!v[0]) return "R9";
        if (v[4] || v[3]) return "R3";
        return "R4";
    endfunction

    initial begin
        @(negedge clk);
        @(negedge clk);
        expect_gates(0, 0, "R2");
        rst_n = 1'b1;
        // Directed sequence, DEAD_CYC = 2.
        cyc(1,0,1,1,1); expect_gates(1, 0, "R3");
        cyc(1,1,1,1,1); expect_gates(1, 0, "R5");
        cyc(0,1,1,1,1); expect_gates(0, 0, "R7");
        cyc(0,1,1,1,1); expect_gates(0, 0, "R11");
        cyc(0,1,1,1,1); expect_gates(0, 0, "R11");
        cyc(0,1,1,1,1); expect_gates(0, 1, "R7");
        cyc(0,0,1,1,1); expect_gates(0, 0, "R4");
        cyc(0,0,1,1,1);
        cyc(0,0,1,1,1);
        cyc(1,1,1,1,1); expect_gates(1, 0, "R6");
        cyc(1,1,0,1,1); expect_gates(0, 0, "R10");
        cyc(1,1,1,1,1); expect_gates(0, 0, "R10");
        cyc(1,0,1,0,1); expect_gates(0, 0, "R8");
        cyc(1,0,1,1,1); expect_gates(0, 0, "R8");
        cyc(0,0,1,1,1);
        cyc(1,0,1,1,1); expect_gates(1, 0, "R8");
        cyc(0,1,1,1,0); expect_gates(0, 0, "R9");
        cyc(0,1,1,1,0);
        cyc(0,1,1,1,0);
        cyc(0,1,1,1,0); expect_gates(0, 0, "R9");
        cyc(0,1,1,1,1); expect_gates(0, 1, "R9");
        // Reset mid-run clears everything.
        rst_n = 1'b0;
        cyc(1,0,1,1,1); expect_gates(0, 0, "R2");
        rst_n = 1'b1;
        // Sweep: every ordered pair of input vectors {hi, lo, prot, hs, ls}.
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                logic [4:0] va, vb;
                va = 5'(a); vb = 5'(b);
                cyc(va[4], va[3], va[2], va[1], va[0]); check_model(tag_of(va));
                for (int k = 0; k < D + 2; k++) begin
                    cyc(vb[4], vb[3], vb[2], vb[1], vb[0]); check_model(tag_of(vb));
                end
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule